// File: doc/BRIEF.md
# Gated-Window Frequency Counter

This block measures how fast an external, free-running square wave toggles. It counts that wave's rising edges while a window of a fixed number of system clock cycles is open. When the window ends, both the window counter and the edge counter stop, so the edge count is a relative measure of the input frequency. An external oscillator whose rate tracks some physical quantity produces the input, and a controlling state machine uses the count.

The controller runs each measurement in two steps. First it pulses a clear request. The block registers that request once, so that a glitch on the controller's output cannot reset the counters. It then zeroes both counters, opens the window and raises a "cleared" handshake. Once the window has closed, the controller pulses a capture request. The block copies the frozen edge count into its output register and raises a "sample ready" handshake. Both handshakes hold until the next clear request. A clear request that arrives while a window is open abandons that window and starts a new one from zero.

Top module: `gwfc_top`

## Requirements
- R1: After reset, freq_val is 0, and clr_done and smp_rdy are both 0.
- R2: A clr_req sampled at clock edge c zeroes both counters and opens the window at edge c+1. If a window is already open, it is abandoned and restarted, and its partial count is lost.
- R3: The window stays open for exactly WIN_LEN clock edges (default 3307), from edge c+2 through edge c+1+WIN_LEN. After that the window counter stops at WIN_LEN and the window stays closed until the next clr_req.
- R4: sig_async passes through a two-flop synchronizer. A rising edge whose high level is first sampled at edge n, with the level sampled at edge n-1 being low, is counted at edge n+2 if the window is open then. Taken together, the rises sampled at edges c through c+WIN_LEN-1 are counted.
- R5: Once the window has closed, further rising edges on sig_async do not change the edge count. A later capture returns the same value.
- R6: The edge counter is CNT_W bits wide (default 10). It saturates at 2^CNT_W-1 (1023) instead of wrapping.
- R7: clr_done goes to 0 at the edge that samples clr_req. It goes to 1 at the following edge and then holds until the next clr_req.
- R8: A cap_req sampled after the window has closed loads the edge count into freq_val and sets smp_rdy at that edge. smp_rdy holds until a clr_req is sampled, and that clr_req clears it at the same edge.
- R9: A cap_req sampled while no window has yet finished (before the first clear, or while a window is open) is ignored. freq_val and smp_rdy keep their values.
- R10: freq_val changes only on an accepted capture. It holds its value between captures, and repeating a capture returns the same value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock; it also times the measurement window |
| rst_n | input | 1 | Active-low reset |
| sig_async | input | 1 | Measured square wave, asynchronous to clk |
| clr_req | input | 1 | Request to clear the counters and start a window |
| cap_req | input | 1 | Request to capture the finished count |
| clr_done | output | 1 | Handshake: counters are cleared and the window is running |
| smp_rdy | output | 1 | Handshake: freq_val holds a fresh sample |
| freq_val | output | CNT_W | Captured edge count |

## Verification
The assertions assume that the controller sends clr_req and cap_req as requests that the clock samples, and that it does not ask for a capture in the same cycle as a clear. They also assume that sig_async, once synchronized, is a plain level whose rises are at least one clock apart. The bench drives every input half a cycle away from the sampling edge, so the synchronizer sees a known value at each edge and the expected count can be computed exactly. It pulses each request for a single cycle. Its patterns include periodic waves, random levels from a fixed seed, a wave toggling every cycle to force saturation, and single pulses placed on the first and last window edges.

// File: rtl/gwfc_pkg.sv
package gwfc_pkg;

  typedef enum logic [1:0] {
    WS_IDLE = 2'd0,
    WS_RUN  = 2'd1,
    WS_DONE = 2'd2
  } win_state_t;

  // Saturating step: value plus one, held at lim.
  function automatic logic [31:0] sat_step(input logic [31:0] v, input logic [31:0] lim);
    return (v >= lim) ? lim : v + 32'd1;
  endfunction

  // True on the cycle where the window counter sits on its final value.
  function automatic logic is_last(input logic [31:0] v, input logic [31:0] len);
    return v == (len - 32'd1);
  endfunction

endpackage

// File: rtl/gwfc_sync.sv
module gwfc_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d_async,
  output logic rise
);
  logic [STAGES-1:0] chain;
  logic              last_q;

  genvar g;
  generate
    for (g = 0; g < STAGES; g++) begin : g_stage
      if (g == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) chain[0] <= 1'b0;
          else        chain[0] <= d_async;
        end
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) chain[g] <= 1'b0;
          else        chain[g] <= chain[g-1];
        end
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) last_q <= 1'b0;
    else        last_q <= chain[STAGES-1];
  end

  assign rise = chain[STAGES-1] & ~last_q;
endmodule

// File: rtl/gwfc_window.sv
module gwfc_window
  import gwfc_pkg::*;
#(
  parameter int WIN_LEN = 3307,
  localparam int WIN_W  = $clog2(WIN_LEN + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             preset,
  output logic             win_open,
  output logic             win_done,
  output logic [WIN_W-1:0] win_cnt
);
  win_state_t state_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= WS_IDLE;
      win_cnt <= '0;
    end else if (preset) begin
      state_q <= WS_RUN;
      win_cnt <= '0;
    end else if (state_q == WS_RUN) begin
      win_cnt <= win_cnt + WIN_W'(1);
      if (is_last(32'(win_cnt), 32'(WIN_LEN))) state_q <= WS_DONE;
    end
  end

  assign win_open = (state_q == WS_RUN);
  assign win_done = (state_q == WS_DONE);
endmodule

// File: rtl/gwfc_edge_cnt.sv
module gwfc_edge_cnt
  import gwfc_pkg::*;
#(
  parameter int CNT_W = 10,
  localparam int CNT_MAX = (1 << CNT_W) - 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             inc,
  output logic [CNT_W-1:0] cnt
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   cnt <= '0;
    else if (clr) cnt <= '0;
    else if (inc) cnt <= CNT_W'(sat_step(32'(cnt), 32'(CNT_MAX)));
  end
endmodule

// File: rtl/gwfc_top.sv
module gwfc_top #(
  parameter int WIN_LEN     = 3307,
  parameter int CNT_W       = 10,
  parameter int SYNC_STAGES = 2,
  localparam int WIN_W      = $clog2(WIN_LEN + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sig_async,
  input  logic             clr_req,
  input  logic             cap_req,
  output logic             clr_done,
  output logic             smp_rdy,
  output logic [CNT_W-1:0] freq_val
);
  // Named internal events, visible to the bound checker.
  logic             clr_q;
  logic             rise;
  logic             win_open;
  logic             win_done;
  logic [WIN_W-1:0] win_cnt;
  logic [CNT_W-1:0] edge_cnt;
  logic             cap_fire;

  // Clear request is registered once so a glitch cannot reach the counters.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) clr_q <= 1'b0;
    else        clr_q <= clr_req;
  end

  gwfc_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk     (clk),
    .rst_n   (rst_n),
    .d_async (sig_async),
    .rise    (rise)
  );

  gwfc_window #(.WIN_LEN(WIN_LEN)) u_win (
    .clk      (clk),
    .rst_n    (rst_n),
    .preset   (clr_q),
    .win_open (win_open),
    .win_done (win_done),
    .win_cnt  (win_cnt)
  );

  gwfc_edge_cnt #(.CNT_W(CNT_W)) u_cnt (
    .clk   (clk),
    .rst_n (rst_n),
    .clr   (clr_q),
    .inc   (rise & win_open),
    .cnt   (edge_cnt)
  );

  assign cap_fire = cap_req & win_done & ~clr_q & ~clr_req;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      clr_done <= 1'b0;
      smp_rdy  <= 1'b0;
      freq_val <= '0;
    end else begin
      if (clr_req)    clr_done <= 1'b0;
      else if (clr_q) clr_done <= 1'b1;

      if (clr_req)       smp_rdy <= 1'b0;
      else if (cap_fire) smp_rdy <= 1'b1;

      if (cap_fire) freq_val <= edge_cnt;
    end
  end
endmodule

// File: rtl/gwfc_checker.sv
module gwfc_checker #(
  parameter int WIN_LEN = 3307,
  parameter int CNT_W   = 10,
  localparam int WIN_W  = $clog2(WIN_LEN + 1),
  localparam int CNT_MAX = (1 << CNT_W) - 1
) (
  input logic             clk,
  input logic             rst_n,
  input logic             clr_req,
  input logic             cap_req,
  input logic             clr_done,
  input logic             smp_rdy,
  input logic [CNT_W-1:0] freq_val,
  input logic             clr_q,
  input logic             rise,
  input logic             win_open,
  input logic             win_done,
  input logic [WIN_W-1:0] win_cnt,
  input logic [CNT_W-1:0] edge_cnt
);
  a_r2_clear_restarts: assert property (@(posedge clk) disable iff (!rst_n)
    clr_q |=> (win_open && edge_cnt == '0 && win_cnt == '0));

  a_r3_window_bound: assert property (@(posedge clk) disable iff (!rst_n)
    32'(win_cnt) <= WIN_LEN);

  a_r3_window_closes: assert property (@(posedge clk) disable iff (!rst_n)
    (win_open && 32'(win_cnt) == WIN_LEN - 1 && !clr_q) |=> (!win_open && win_done));

  a_r4_counts_rise: assert property (@(posedge clk) disable iff (!rst_n)
    (win_open && rise && !clr_q && 32'(edge_cnt) != CNT_MAX)
      |=> 32'(edge_cnt) == 32'($past(edge_cnt)) + 1);

  a_r5_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    (!win_open && !clr_q) |=> $stable(edge_cnt));

  a_r6_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
    (32'(edge_cnt) == CNT_MAX && !clr_q) |=> 32'(edge_cnt) == CNT_MAX);

  a_r7_cleared_ack: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_q && !clr_req) |=> clr_done);

  a_r8_handshakes_drop: assert property (@(posedge clk) disable iff (!rst_n)
    clr_req |=> (!clr_done && !smp_rdy));

  a_r9_early_capture_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (cap_req && !win_done && !clr_req) |=> ($stable(freq_val) && $stable(smp_rdy)));

  a_r10_value_holds: assert property (@(posedge clk) disable iff (!rst_n)
    !cap_req |=> $stable(freq_val));
endmodule

bind gwfc_top gwfc_checker #(.WIN_LEN(WIN_LEN), .CNT_W(CNT_W)) u_gwfc_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .clr_req  (clr_req),
  .cap_req  (cap_req),
  .clr_done (clr_done),
  .smp_rdy  (smp_rdy),
  .freq_val (freq_val),
  .clr_q    (clr_q),
  .rise     (rise),
  .win_open (win_open),
  .win_done (win_done),
  .win_cnt  (win_cnt),
  .edge_cnt (edge_cnt)
);

// File: tb/test_gwfc_top.sv
module test_gwfc_top;
  localparam int WIN_LEN = 3307;
  localparam int CNT_W   = 10;
  localparam int CMAX    = (1 << CNT_W) - 1;
  localparam int TAIL    = 40;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             sig_async = 1'b0;
  logic             clr_req = 1'b0;
  logic             cap_req = 1'b0;
  logic             clr_done;
  logic             smp_rdy;
  logic [CNT_W-1:0] freq_val;

  int n_tests = 0;
  int n_fail  = 0;
  int last_val = 0;
  bit finished = 1'b0;

  always #2 clk = ~clk;

  gwfc_top #(.WIN_LEN(WIN_LEN), .CNT_W(CNT_W)) i_gwfc_top (
    .clk       (clk),
    .rst_n     (rst_n),
    .sig_async (sig_async),
    .clr_req   (clr_req),
    .cap_req   (cap_req),
    .clr_done  (clr_done),
    .smp_rdy   (smp_rdy),
    .freq_val  (freq_val)
  );

  task automatic chk(input string req, input int act, input int exp);
    n_tests++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: got %0d expected %0d", req, act, exp);
    end
  endtask

  // Expected count after saturation (R6).
  function automatic int sat_expect(input int n);
    return (n > CMAX) ? CMAX : n;
  endfunction

  // Level driven in cycle i of a window: 0 periodic, 1 random, 2 toggling, 3 single pulse at p.
  function automatic bit level_at(input int mode, input int i, input int p);
    case (mode)
      0:       return (i % p) < (p / 2);
      1:       return 1'($urandom());
      2:       return 1'(i & 1);
      default: return i == p;
    endcase
  endfunction

  // Clears, runs a window (or aborts it at cycle abort_at), returns the expected count.
  task automatic run_window(input int mode, input int p, input int abort_at, output int exp);
    bit prev;
    bit v;
    int cnt;
    prev = sig_async;
    cnt = 0;
    for (int i = 0; i < WIN_LEN + TAIL; i++) begin
      @(negedge clk);
      if (i == 1) begin
        chk("R7 clr_done low after request", int'(clr_done), 0);
        chk("R8 smp_rdy dropped by clear", int'(smp_rdy), 0);
      end
      if (i == 2) chk("R7 clr_done raised", int'(clr_done), 1);
      if (i == 102) begin
        chk("R9 capture during window: smp_rdy", int'(smp_rdy), 0);
        chk("R9 capture during window: freq_val", int'(freq_val), last_val);
      end
      if (abort_at > 0 && i == abort_at) begin
        exp = -1;
        return;
      end
      clr_req = (i == 0);
      cap_req = (i == 100);
      v = level_at(mode, i, p);
      sig_async = v;
      if (i < WIN_LEN && v && !prev) cnt++;
      prev = v;
    end
    exp = sat_expect(cnt);
  endtask

  task automatic capture(input string req, input int exp);
    @(negedge clk);
    cap_req = 1'b1;
    @(negedge clk);
    cap_req = 1'b0;
    chk({req, " smp_rdy"}, int'(smp_rdy), 1);
    chk({req, " freq_val"}, int'(freq_val), exp);
    last_val = int'(freq_val);
  endtask

  initial begin
    int exp;
    void'($urandom(32'h5eed_1234));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 reset freq_val", int'(freq_val), 0);
    chk("R1 reset clr_done", int'(clr_done), 0);
    chk("R1 reset smp_rdy", int'(smp_rdy), 0);

    // R9: a capture before any window is ignored.
    cap_req = 1'b1;
    @(negedge clk);
    cap_req = 1'b0;
    @(negedge clk);
    chk("R9 early capture smp_rdy", int'(smp_rdy), 0);
    chk("R9 early capture freq_val", int'(freq_val), 0);

    // Periodic wave, period 9 cycles.
    run_window(0, 9, 0, exp);
    capture("R4 periodic", exp);
    @(negedge clk);
    chk("R10 value holds", int'(freq_val), exp);
    capture("R10 repeated capture", exp);

    // Window boundaries: single pulses (R3/R4).
    run_window(3, 0, 0, exp);
    capture("R4 pulse at first edge", exp);
    run_window(3, WIN_LEN - 1, 0, exp);
    chk("R3 last window edge expected", exp, 1);
    capture("R3 pulse at last edge", exp);
    run_window(3, WIN_LEN, 0, exp);
    chk("R3 after window expected", exp, 0);
    capture("R5 pulse after close", exp);

    // Saturation: toggle every cycle gives about 1650 rises.
    run_window(2, 0, 0, exp);
    chk("R6 saturation expected", exp, CMAX);
    capture("R6 saturated", exp);

    // Abort mid-window, then a full window (R2).
    run_window(0, 6, 1500, exp);
    run_window(0, 14, 0, exp);
    capture("R2 restart after abort", exp);

    // Random levels and random periods.
    for (int k = 0; k < 3; k++) begin
      run_window(1, 0, 0, exp);
      capture("R4 random levels", exp);
      run_window(0, 4 + int'($urandom_range(0, 20)), 0, exp);
      capture("R4 random period", exp);
    end

    finished = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      n_tests++;
      n_fail++;
      $display("FAIL R3 watchdog expired: got 0 expected 1");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end
endmodule